// File: doc/BRIEF.md
# Bit Clock Recovery and NRZI Slicer

This block sits behind a tone demodulator. It accepts one signed sample per `sample_valid_i` strobe and returns one decoded data bit per recovered bit period. Each accepted sample passes through a small recursive low-pass stage. The filter output is then sliced to a hard bit by its sign. The slices enter a short history register.

A phase accumulator advances by one eighth of a bit period per accepted sample. Whenever two successive slices differ, the accumulator is nudged toward the point that places signal edges half a bit away from the decision instant. When the accumulator crosses one full period, it wraps. In that same sample, a majority vote over the newest slices yields the line bit. The line bit is compared with the previous one to undo NRZI coding: equal neighbours give a 1 and differing neighbours give a 0. The result leaves on `bit_o` with a one-clock `bit_valid_o` strobe, one clock after the deciding sample was accepted.

Top module: `bit_clock_slicer`

## Requirements
- R1: For each accepted sample x, the filter computes y = x_prev + x + (y_prev >>> 1), where x_prev and y_prev are the values from the previously accepted sample. The slice is 1 only when y > 0; y equal to zero slices to 0.
- R2: Each accepted sample advances the phase by STEP (8). With no slice toggles, after reset a bit is emitted on every 8th accepted sample (the 8th, 16th, and so on).
- R3: When the newest two slices differ and the phase before the sample is below THRESH (32), CORR (1) is added before the step. For example, a toggle on the 4th sample after reset still gives a strobe on the 8th and 16th samples.
- R4: When a toggle occurs with the phase at or above THRESH, CORR is subtracted before the step. The phase wraps modulo PERIOD (64) when it reaches PERIOD. A toggle on the 5th sample after reset (phase exactly 32) moves the strobes to the 9th and 17th samples.
- R5: At a wrap, the line bit is 1 when at least two of the three newest slices, including the current one, are 1.
- R6: `bit_o` is 1 when the current line bit equals the previous line bit, and 0 otherwise. The previous line bit is 0 after reset.
- R7: `bit_valid_o` is high for exactly one clock. It rises in the clock after the deciding sample was accepted.
- R8: While `rst_ni` is low, the filter state, the slice history, the line bit history, the phase, `bit_valid_o` and `bit_o` are all cleared to zero.
- R9: Samples presented while `sample_valid_i` is low change no state and produce no output bit.
- R10: The block decodes an NRZI stream of levels of magnitude 100 without error after a preamble of 48 toggling bits. This holds while bit lengths vary through 8, 9, 8 and 7 samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Sample strobe |
| sample_i | input | SAMPLE_W | Signed demodulator sample |
| bit_valid_o | output | 1 | One-clock strobe per decoded bit |
| bit_o | output | 1 | NRZI-decoded data bit |

## Verification
The bench builds the block with its defaults: 8-bit samples, a 10-bit filter, step 8, period 64, threshold 32, correction 1 and a 3-slice vote. With these values a single step placed on the 4th or 5th sample after reset lands exactly below, or exactly on, the half-period threshold. That exposes the correction direction and the threshold comparison through the strobe position. Exact zero-valued filter outputs separate the strict sign test from a non-strict one. A hand-built slice pattern of 1,1,0 at a wrap separates a majority vote from a newest-slice decision. A long NRZI stream with 7 to 9 samples per bit exercises lock and tracking.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[1] & v[2]) | (v[0] & v[2]);
  endfunction

endpackage

// File: rtl/bcs_lowpass_slicer.sv
module bcs_lowpass_slicer #(
  parameter int SAMPLE_W = 8,
  parameter int FILT_W   = 10,
  parameter int HIST_W   = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  output logic        [HIST_W-1:0]   hist_next_o,
  output logic                       toggle_o
);
  localparam int SUM_W = FILT_W + 2;
  localparam int Y_MAX = 2 ** (FILT_W - 1) - 1;
  localparam int Y_MIN = -(2 ** (FILT_W - 1));

  logic signed [SAMPLE_W-1:0] x_prev_q;
  logic signed [FILT_W-1:0]   y_q;
  logic        [HIST_W-1:0]   hist_q;
  logic signed [SUM_W-1:0]    sum_w;
  logic signed [FILT_W-1:0]   y_next;
  logic                       slice;

  always_comb begin
    sum_w  = SUM_W'(x_prev_q) + SUM_W'(sample_i) + SUM_W'(y_q >>> 1);
    y_next = sum_w[FILT_W-1:0];
    slice  = (y_next > 0);
    hist_next_o = {hist_q[HIST_W-2:0], slice};
    toggle_o    = hist_next_o[1] ^ hist_next_o[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_prev_q <= '0;
      y_q      <= '0;
      hist_q   <= '0;
    end else if (valid_i) begin
      x_prev_q <= sample_i;
      y_q      <= y_next;
      hist_q   <= hist_next_o;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (int'(sum_w) <= Y_MAX && int'(sum_w) >= Y_MIN)); // R1

  AST_FILTER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(y_q) && $stable(hist_q))); // R9

endmodule

// File: rtl/bcs_phase_tracker.sv
module bcs_phase_tracker #(
  parameter int STEP   = 8,
  parameter int PERIOD = 64,
  parameter int THRESH = 32,
  parameter int CORR   = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic toggle_i,
  output logic wrap_o
);
  localparam int PH_W = $clog2(PERIOD + STEP + CORR + 1) + 1;
  localparam logic signed [PH_W-1:0] C_STEP = PH_W'(STEP);
  localparam logic signed [PH_W-1:0] C_PER  = PH_W'(PERIOD);
  localparam logic signed [PH_W-1:0] C_THR  = PH_W'(THRESH);
  localparam logic signed [PH_W-1:0] C_CORR = PH_W'(CORR);

  logic signed [PH_W-1:0] ph_q, adj, stepped, ph_d;

  always_comb begin
    adj = ph_q;
    if (toggle_i) adj = (ph_q < C_THR) ? ph_q + C_CORR : ph_q - C_CORR;
    stepped = adj + C_STEP;
    wrap_o  = valid_i && (stepped >= C_PER);
    if (stepped >= C_PER)   ph_d = stepped - C_PER;
    else if (stepped < 0)   ph_d = stepped + C_PER;
    else                    ph_d = stepped;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ph_q <= '0;
    else if (valid_i) ph_q <= ph_d;
  end

  AST_PHASE_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q >= 0 && ph_q < C_PER)); // R4

  AST_PHASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(ph_q)); // R9

  AST_FREE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !toggle_i && ph_q < C_PER - C_STEP) |=> (ph_q == $past(ph_q) + C_STEP)); // R2

  AST_NUDGE_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && toggle_i && ph_q < C_THR && ph_q + C_CORR + C_STEP < C_PER)
    |=> (ph_q == $past(ph_q) + C_CORR + C_STEP)); // R3

endmodule

// File: rtl/bcs_bit_decider.sv
module bcs_bit_decider #(
  parameter int VOTE_N = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              decide_i,
  input  logic [VOTE_N-1:0] votes_i,
  output logic              valid_o,
  output logic              bit_o
);
  logic decided, prev_q;

  if (VOTE_N == 3) begin : g_maj3
    assign decided = bcs_pkg::maj3(votes_i[2:0]);
  end else begin : g_count
    assign decided = ($countones(votes_i) > VOTE_N / 2);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      bit_o   <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= decide_i;
      if (decide_i) begin
        prev_q <= decided;
        bit_o  <= (decided == prev_q);
      end
    end
  end

  AST_STEADY_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decide_i && (&votes_i) && prev_q) |=> (valid_o && bit_o)); // R6

  AST_VOTE_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decide_i && (votes_i == '0) && prev_q) |=> (valid_o && !bit_o)); // R5

endmodule

// File: rtl/bit_clock_slicer.sv
module bit_clock_slicer #(
  parameter int SAMPLE_W = 8,
  parameter int FILT_W   = 10,
  parameter int STEP     = 8,
  parameter int PERIOD   = 64,
  parameter int THRESH   = 32,
  parameter int CORR     = 1,
  parameter int VOTE_N   = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sample_valid_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  output logic                       bit_valid_o,
  output logic                       bit_o
);
  logic [VOTE_N-1:0] hist_next;
  logic              toggle, wrap;

  bcs_lowpass_slicer #(.SAMPLE_W(SAMPLE_W), .FILT_W(FILT_W), .HIST_W(VOTE_N)) u_slice (
    .clk_i, .rst_ni, .valid_i(sample_valid_i), .sample_i,
    .hist_next_o(hist_next), .toggle_o(toggle)
  );

  bcs_phase_tracker #(.STEP(STEP), .PERIOD(PERIOD), .THRESH(THRESH), .CORR(CORR)) u_phase (
    .clk_i, .rst_ni, .valid_i(sample_valid_i), .toggle_i(toggle), .wrap_o(wrap)
  );

  bcs_bit_decider #(.VOTE_N(VOTE_N)) u_dec (
    .clk_i, .rst_ni, .decide_i(wrap), .votes_i(hist_next),
    .valid_o(bit_valid_o), .bit_o
  );

  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |=> !bit_valid_o); // R7

  AST_STROBE_AFTER_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |-> $past(sample_valid_i)); // R9

endmodule

// File: tb/sim_bit_clock_slicer.sv
module sim_bit_clock_slicer;
  localparam int CLK_PERIOD = 10;
  localparam int NBITS = 136;

  logic clk = 1'b0, rst_ni = 1'b0, sample_valid_i = 1'b0;
  logic signed [7:0] sample_i = '0;
  logic bit_valid_o, bit_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bit_clock_slicer u0 (.clk_i(clk), .rst_ni, .sample_valid_i, .sample_i, .bit_valid_o, .bit_o);

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 0; sample_valid_i = 0; sample_i = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
  endtask

  task automatic push(input int x, output logic v, output logic d);
    @(negedge clk); sample_valid_i = 1; sample_i = x[7:0];
    @(negedge clk); v = bit_valid_o; d = bit_o; sample_valid_i = 0;
    @(negedge clk);
    if (v) chk("R7", int'(bit_valid_o), 0, "strobe width");
  endtask

  // feed n samples of value x starting at sample index first; count strobes
  task automatic feed(input int x, input int n, inout int idx, output int cnt,
                      output int last_idx, output logic last_d);
    logic v, d;
    cnt = 0; last_idx = -1; last_d = 0;
    for (int i = 0; i < n; i++) begin
      idx++;
      push(x, v, d);
      if (v) begin cnt++; last_idx = idx; last_d = d; end
    end
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R8", int'(bit_valid_o), 0, "valid after reset");
    chk("R8", int'(bit_o), 0, "bit after reset");
  endtask

  task automatic t_idle_and_zero();
    int idx = 0, c, li; logic ld; int seen = 0;
    do_reset();
    sample_i = 8'sd100;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (bit_valid_o) seen++; end
    chk("R9", seen, 0, "strobes while valid low");
    feed(0, 7, idx, c, li, ld);
    chk("R2", c, 0, "strobes in samples 1..7");
    feed(0, 1, idx, c, li, ld);
    chk("R2", c, 1, "strobe at sample 8");
    chk("R1", int'(ld), 1, "zero input slices to 0, NRZI 0,0");
    chk("R9", int'(ld), 1, "ignored samples left filter clear");
    feed(0, 8, idx, c, li, ld);
    chk("R2", li, 16, "second strobe index");
  endtask

  task automatic t_nudge_up();
    int idx = 0, c, li; logic ld;
    do_reset();
    feed(0, 3, idx, c, li, ld);
    feed(100, 4, idx, c, li, ld);
    chk("R3", c, 0, "no strobe in samples 4..7");
    feed(100, 1, idx, c, li, ld);
    chk("R3", li, 8, "strobe stays at sample 8");
    chk("R6", int'(ld), 0, "line 0 then 1 gives 0");
    feed(100, 8, idx, c, li, ld);
    chk("R3", li, 16, "strobe at sample 16");
    chk("R6", int'(ld), 1, "line 1 then 1 gives 1");
  endtask

  task automatic t_nudge_down();
    int idx = 0, c, li; logic ld;
    do_reset();
    feed(0, 4, idx, c, li, ld);
    feed(100, 4, idx, c, li, ld);
    chk("R4", c, 0, "no strobe at sample 8 after threshold toggle");
    feed(100, 1, idx, c, li, ld);
    chk("R4", li, 9, "strobe moved to sample 9");
    feed(100, 8, idx, c, li, ld);
    chk("R4", li, 17, "strobe at sample 17 after wrap");
  endtask

  task automatic t_majority();
    int idx = 0, c, li; logic ld;
    do_reset();
    feed(0, 22, idx, c, li, ld);
    chk("R2", c, 2, "strobes in samples 1..22");
    feed(100, 1, idx, c, li, ld);
    feed(0, 1, idx, c, li, ld);
    chk("R4", c, 0, "no strobe at sample 24");
    feed(-127, 1, idx, c, li, ld);
    chk("R4", li, 25, "strobe at sample 25");
    chk("R5", int'(ld), 0, "slices 1,1,0 vote 1 after 0");
  endtask

  task automatic t_lock();
    logic d[NBITS];
    logic outb[512];
    int cnt = 0, best = 1 << 30;
    logic [6:0] lf = 7'h5A;
    int lvl = -100;
    logic v, dd;
    do_reset();
    for (int k = 0; k < NBITS; k++) begin
      if (k >= 48 && k < 128) begin
        d[k] = lf[6] ^ lf[5]; lf = {lf[5:0], lf[6] ^ lf[5]};
      end else d[k] = 0;
    end
    for (int k = 0; k < NBITS; k++) begin
      int len;
      if (d[k] == 0) lvl = -lvl;
      case (k % 4) 1: len = 9; 3: len = 7; default: len = 8; endcase
      for (int s = 0; s < len; s++) begin
        push(lvl, v, dd);
        if (v && cnt < 512) begin outb[cnt] = dd; cnt++; end
      end
    end
    for (int o = -4; o <= 4; o++) begin
      int m = 0;
      for (int k = 56; k < 128; k++) begin
        int j = k + o;
        if (j < 0 || j >= cnt) m++;
        else if (outb[j] != d[k]) m++;
      end
      if (m < best) best = m;
    end
    chk("R10", best, 0, "payload mismatches at best alignment");
    chk("R6", int'(cnt >= NBITS - 3 && cnt <= NBITS + 3), 1, "decoded bit count");
  endtask

  initial begin
    t_reset();
    t_idle_and_zero();
    t_nudge_up();
    t_nudge_down();
    t_majority();
    t_lock();
    t_reset();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule